// File: doc/BRIEF.md
# Rate-Corrected DDS Tuning Controller

This block drives a 48-bit phase accumulator whose step, the tuning word, tracks an external timing reference even though the accumulator's own clock is left uncorrected. A timing receiver measures how fast this clock runs against the reference and reports the error in parts per 10^12 (picoseconds per second). Each time a new estimate arrives, the block divides the programmed nominal tuning word by (1 + e) to get a corrected word. The accumulator then steps by that word on every clock. The top bits of the accumulator give a square wave whose average rate follows the reference.

The division is a sequential restoring divide that yields one quotient bit per cycle. The active word is replaced only on the cycle after a divide ends, so the accumulator never sees a partly computed value. The error input has a valid strobe and never applies back-pressure, so every strobe is taken. A sample that arrives while a divide is running waits in a single holding slot, and a newer sample overwrites it. Control and status pins (reset, nominal word, busy flag) are plain levels.

Top module: `dds_rate_tuner`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tune_word` takes the value of `nom_word`, the accumulator clears to 0 (`phase_msb` = 0) and `calc_busy` is low.
- R2: Out of reset, the 48-bit accumulator adds `tune_word` at every clock edge, modulo 2^48. `phase_msb` shows its top 4 bits (bits 47..44).
- R3: A processed sample e, read as a two's-complement count of 10^-12 units, yields the word round(nom × 10^12 / (10^12 + e)), computed as floor((nom × 10^12 + floor(D/2)) / D) with D = 10^12 + e. A sample of e = 0 gives back the nominal word exactly.
- R4: `err_valid` is never back-pressured. A strobe in any cycle is accepted, and `calc_busy` is high in the following cycle.
- R5: When the divider is idle and nothing is held, a sample accepted at clock edge s makes `tune_word` change at edge s+50 (49 divide steps plus one load). At that same edge `calc_busy` falls. `tune_word` changes only on such a load edge.
- R6: A sample that arrives during a divide is held. Its divide starts at the edge right after the running one completes, which is the load edge of the earlier result. Its result therefore loads 50 edges after that, and `calc_busy` stays high in between.
- R7: Only the newest held sample is kept. An earlier sample that is overwritten while it waits never reaches `tune_word`.
- R8: A quotient above 2^48 − 1 loads as all ones (48'hFFFF_FFFF_FFFF).
- R9: `nom_word` is sampled at the edge where a divide starts. Changing it later has no effect on that divide's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Accumulator and controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_valid | input | 1 | Strobe marking a new rate-error sample |
| err_ppt | input | 32 | Signed rate error in units of 10^-12 |
| nom_word | input | 48 | Nominal tuning word, valid for zero error |
| phase_msb | output | 4 | Top bits of the phase accumulator |
| tune_word | output | 48 | Tuning word currently applied to the accumulator |
| calc_busy | output | 1 | High while a sample is held, being divided or being loaded |

## Verification
Every corrected word is due exactly 50 edges after its divide starts. The bench records the edge on which it raised each strobe, adds 50, and queues the expected word with that edge number. A monitor compares `tune_word` on the falling edge after that exact edge, so a load one cycle early or late is caught. For a held sample the start edge is the load edge of the earlier result, and its result is due 100 edges after the first strobe. The bench also samples the word one edge before each load to confirm it has not yet moved. The accumulator's output is checked on each falling edge against the count of rising edges since reset.

// File: rtl/dds_tune_pkg.sv
package dds_tune_pkg;
  // Error samples are counted in units of 1e-12 of the clock rate.
  localparam logic [63:0] PPT_SCALE = 64'd1000000000000;

  typedef enum logic {
    DIV_IDLE,
    DIV_RUN
  } div_state_e;
endpackage

// File: rtl/dds_sample_hold.sv
module dds_sample_hold #(
  parameter int ERR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ERR_W-1:0] in_err,
  input  logic             div_busy,
  output logic             start,
  output logic [ERR_W-1:0] start_err,
  output logic             pend_vld
);
  logic [ERR_W-1:0] pend_err;

  // Held sample takes precedence; a fresh one then waits in the slot.
  assign start     = !div_busy && (in_valid || pend_vld);
  assign start_err = pend_vld ? pend_err : in_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_err <= '0;
    end else if (start) begin
      pend_vld <= pend_vld && in_valid;
      if (pend_vld && in_valid) pend_err <= in_err;
    end else if (in_valid) begin
      pend_vld <= 1'b1;
      pend_err <= in_err;
    end
  end
endmodule

// File: rtl/dds_restoring_div.sv
module dds_restoring_div
  import dds_tune_pkg::*;
#(
  parameter int NUM_W = 89,
  parameter int DEN_W = 41,
  parameter int Q_W   = 49
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [Q_W-1:0]   quot
);
  localparam int CNT_W = $clog2(Q_W + 1);

  div_state_e       state;
  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] den_q;
  logic [Q_W-1:0]   low_q;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W:0]   trial;
  logic [DEN_W-1:0] diff;
  logic             ge;

  always_comb begin
    trial = {rem, low_q[Q_W-1]};
    ge    = trial >= {1'b0, den_q};
    diff  = trial[DEN_W-1:0] - den_q;
  end

  assign busy = (state == DIV_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= DIV_IDLE;
      done  <= 1'b0;
      cnt   <= '0;
      rem   <= '0;
      den_q <= '0;
      low_q <= '0;
      quot  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        DIV_IDLE: begin
          if (start) begin
            // Upper numerator part is below the divisor, so Q_W steps suffice.
            rem   <= DEN_W'(num[NUM_W-1:Q_W]);
            low_q <= num[Q_W-1:0];
            den_q <= den;
            cnt   <= '0;
            state <= DIV_RUN;
          end
        end
        DIV_RUN: begin
          rem   <= ge ? diff : trial[DEN_W-1:0];
          quot  <= {quot[Q_W-2:0], ge};
          low_q <= low_q << 1;
          cnt   <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(Q_W - 1)) begin
            state <= DIV_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= DIV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 48,
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] step,
  output logic [OUT_W-1:0] msb
);
  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc + step;
  end

  assign msb = acc[ACC_W-1 -: OUT_W];
endmodule

// File: rtl/dds_rate_tuner.sv
module dds_rate_tuner
  import dds_tune_pkg::*;
#(
  parameter int          ACC_W = 48,
  parameter int          ERR_W = 32,
  parameter int          OUT_W = 4,
  parameter logic [63:0] SCALE = PPT_SCALE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_valid,
  input  logic [ERR_W-1:0] err_ppt,
  input  logic [ACC_W-1:0] nom_word,
  output logic [OUT_W-1:0] phase_msb,
  output logic [ACC_W-1:0] tune_word,
  output logic             calc_busy
);
  localparam int SCL_W = $clog2(SCALE);
  localparam int DEN_W = SCL_W + 1;
  localparam int NUM_W = ACC_W + SCL_W + 1;
  localparam int Q_W   = ACC_W + 1;

  logic             start;
  logic [ERR_W-1:0] start_err;
  logic             pend_vld;
  logic             div_busy;
  logic             div_done;
  logic [Q_W-1:0]   quot;
  logic [DEN_W-1:0] den;
  logic [NUM_W-1:0] num;

  dds_sample_hold #(.ERR_W(ERR_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (err_valid),
    .in_err   (err_ppt),
    .div_busy (div_busy),
    .start    (start),
    .start_err(start_err),
    .pend_vld (pend_vld)
  );

  // Divisor is the scale plus the signed error; half of it rounds the quotient.
  always_comb begin
    den = DEN_W'(SCALE) + {{(DEN_W-ERR_W){start_err[ERR_W-1]}}, start_err};
    num = NUM_W'(nom_word) * NUM_W'(SCALE) + NUM_W'(den >> 1);
  end

  dds_restoring_div #(.NUM_W(NUM_W), .DEN_W(DEN_W), .Q_W(Q_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .num  (num),
    .den  (den),
    .busy (div_busy),
    .done (div_done),
    .quot (quot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        tune_word <= nom_word;
    else if (div_done) tune_word <= quot[Q_W-1] ? '1 : quot[ACC_W-1:0];
  end

  assign calc_busy = div_busy | pend_vld | div_done;

  dds_phase_acc #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_acc (
    .clk  (clk),
    .rst_n(rst_n),
    .step (tune_word),
    .msb  (phase_msb)
  );
endmodule

// File: rtl/dds_rate_tuner_chk.sv
module dds_rate_tuner_chk #(
  parameter int ACC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_valid,
  input logic             calc_busy,
  input logic [ACC_W-1:0] tune_word,
  input logic             div_busy,
  input logic             div_done,
  input logic             pend_vld
);
  // R4: an accepted strobe is always followed by a busy cycle
  p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> calc_busy);

  // R5: the active word moves only out of a busy period
  p_word_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tune_word) |-> $past(calc_busy));

  // R5: completion is only signalled after the divider has been running
  p_done_after_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> $past(div_busy));

  // R6: a held sample is launched as soon as the divider is free
  p_pending_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && !div_busy) |=> div_busy);
endmodule

bind dds_rate_tuner dds_rate_tuner_chk #(.ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .err_valid(err_valid),
  .calc_busy(calc_busy),
  .tune_word(tune_word),
  .div_busy (div_busy),
  .div_done (div_done),
  .pend_vld (pend_vld)
);

// File: tb/dds_rate_tuner_tb_top.sv
`timescale 1ns/1ps
module dds_rate_tuner_tb_top;
  localparam int          ACC_W = 48;
  localparam int          ERR_W = 32;
  localparam int          OUT_W = 4;
  localparam int          LAT   = 50;
  localparam logic [47:0] NOMX  = 48'd52776558133380;
  localparam logic [47:0] EX_W  = 48'd52776552802262;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             err_valid = 1'b0;
  logic [ERR_W-1:0] err_ppt = '0;
  logic [ACC_W-1:0] nom_word = '0;
  logic [OUT_W-1:0] phase_msb;
  logic [ACC_W-1:0] tune_word;
  logic             calc_busy;

  always #2 clk = ~clk;

  dds_rate_tuner dut_i (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ppt(err_ppt),
    .nom_word(nom_word), .phase_msb(phase_msb), .tune_word(tune_word),
    .calc_busy(calc_busy)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int          due_q[$];
  logic [47:0] word_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string tag,
                       input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [47:0] model(input logic [47:0] nom, input int e);
    longint d;
    logic [127:0] n, q;
    d = 64'sd1000000000000 + longint'(e);
    n = 128'(nom) * 128'd1000000000000 + 128'(d / 2);
    q = n / 128'(d);
    if (q > 128'h0000_FFFF_FFFF_FFFF) return '1;
    return q[47:0];
  endfunction

  task automatic expect_at(input int due, input logic [47:0] w, input string tag);
    due_q.push_back(due);
    word_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  // Scoreboard monitor: compares the word after the exact load edge.
  always @(negedge clk) begin
    if (due_q.size() != 0 && cyc == due_q[0]) begin
      check(tune_word == word_q[0], tag_q[0], tune_word, word_q[0]);
      void'(due_q.pop_front());
      void'(word_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic pulse_err(input int e, output int edge_no);
    @(negedge clk);
    err_valid = 1'b1;
    err_ppt   = e;
    edge_no   = cyc + 1;
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  task automatic wait_edge(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [47:0] nom);
    @(negedge clk);
    rst_n = 1'b0;
    nom_word = nom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at edge %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s, b, c;
    longint dw;
    nom_word = 48'h1 << 44;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(tune_word == (48'h1 << 44), "R1 word", tune_word, 48'h1 << 44);
    check(phase_msb == '0, "R1 phase", 48'(phase_msb), 0);
    check(calc_busy == 1'b0, "R1 busy", 48'(calc_busy), 0);
    rst_n = 1'b1;
    // R2: step 2^44 advances the top nibble by one per edge
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      check(phase_msb == OUT_W'(k), "R2 phase", 48'(phase_msb), 48'(k % 16));
    end

    do_reset(NOMX);
    check(tune_word == NOMX, "R1 word after reset", tune_word, NOMX);

    // R3: zero error returns the nominal word
    pulse_err(0, s);
    expect_at(s + LAT, NOMX, "R3 zero error");
    wait_edge(s + LAT + 1);

    // R3/R4/R5: reference example and exact timing
    pulse_err(101013, s);
    expect_at(s + LAT, model(NOMX, 101013), "R3 example");
    check(calc_busy == 1'b1, "R4 busy after strobe", 48'(calc_busy), 1);
    wait_edge(s + LAT - 1);
    check(tune_word == NOMX, "R5 word held before load", tune_word, NOMX);
    check(calc_busy == 1'b1, "R5 busy before load", 48'(calc_busy), 1);
    wait_edge(s + LAT);
    check(calc_busy == 1'b0, "R5 busy falls at load", 48'(calc_busy), 0);
    dw = longint'(tune_word) - longint'(EX_W);
    check(dw >= -1 && dw <= 1, "R3 example within 1 LSB", tune_word, EX_W);

    // R3: negative error raises the word
    pulse_err(-2000000, s);
    expect_at(s + LAT, model(NOMX, -2000000), "R3 negative error");
    wait_edge(s + LAT + 1);

    // R6/R7: samples during a divide; only the newest one is kept
    pulse_err(500000, s);
    expect_at(s + LAT, model(NOMX, 500000), "R6 first result");
    wait_edge(s + 4);
    pulse_err(-700000, b);
    wait_edge(s + 9);
    pulse_err(1234567, c);
    expect_at(s + 2 * LAT, model(NOMX, 1234567), "R7 newest held sample");
    wait_edge(s + LAT);
    check(calc_busy == 1'b1, "R6 busy across held sample", 48'(calc_busy), 1);
    wait_edge(s + 2 * LAT - 1);
    check(tune_word == model(NOMX, 500000), "R7 overwritten sample unused",
          tune_word, model(NOMX, 500000));
    wait_edge(s + 2 * LAT + 1);

    // R9: nominal word changed after the divide has started
    pulse_err(300000, s);
    wait_edge(s + 3);
    nom_word = 48'h1 << 40;
    expect_at(s + LAT, model(NOMX, 300000), "R9 nominal latched at start");
    wait_edge(s + LAT + 10);
    check(tune_word == model(NOMX, 300000), "R9 word unaffected later",
          tune_word, model(NOMX, 300000));

    // R8: quotient above the word range saturates
    do_reset(48'hFFFF_FFF0_0000);
    pulse_err(-1000000000, s);
    expect_at(s + LAT, 48'hFFFF_FFFF_FFFF, "R8 saturation");
    wait_edge(s + LAT + 2);

    check(due_q.size() == 0, "scoreboard drained", 48'(due_q.size()), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule